// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital timing controller that sits beside a successive-approximation converter. Software writes a 4-bit frequency-select code that sets a clock divider `div`. From `div` the block produces three phases. The first is a one-time stabilization wait. The second is a sample-and-hold window, which opens each conversion. The third is a conversion window. An end-of-conversion pulse marks the last tick of the conversion.

All timing is counted on `tick_i`, a clock enable at twice the base-clock rate. One tick is therefore half a base clock. This lets the 16.5 × div base-clock sampling length be counted exactly as 33 × div ticks. Only the first conversion after the block is enabled waits for stabilization. Conversions that follow back to back start sampling at once. A select code with its top bit set is illegal. It raises an error flag and blocks new starts.

Top module: `adc_seq_timing`

## Requirements
- R1: After reset, and while enable is low, `sample_o`, `convert_o`, `eoc_o` and `cfg_err_o` are all low.
- R2: Select codes 0..7 (bits [2:0], top bit 0) give `div = code + 1`. The sampling window (`sample_o` high) lasts 33 × div ticks.
- R3: The conversion window (`convert_o` high) follows the sampling window directly. It lasts 29 × div ticks, so the whole conversion is 62 × div ticks.
- R4: The first conversion after enable rises waits before sampling. The wait is 32, 62 or 94 ticks for div 1, 2 or 3, and 100 ticks for div 4..8. All outputs stay low during the wait.
- R5: If the start request is high on the last tick of a conversion, the next sampling window opens on the following tick with no stabilization wait.
- R6: `eoc_o` is a single-cycle pulse. It occurs only on the last tick of the conversion window, while `convert_o` is high.
- R7: A select code with bit 3 set makes `cfg_err_o` high from the next clock. While such a code is present, no conversion starts. `cfg_err_o` clears on the clock after a legal code is written.
- R8: Driving enable low returns `sample_o` and `convert_o` low on the next clock, in any phase. The next enable must wait for stabilization again.
- R9: The select code is captured when a conversion starts. Changing it during that conversion does not alter the conversion's window lengths.
- R10: Phases advance only on cycles where `tick_i` is high. With `tick_i` low, `sample_o` and `convert_o` hold.
- R11: `sample_o` and `convert_o` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timing enable at twice the base-clock rate |
| enable_i | input | 1 | Converter enable; low aborts and re-arms stabilization |
| start_i | input | 1 | Start request, level sensitive |
| fsel_i | input | 4 | Frequency-select code; bit 3 set is illegal |
| sample_o | output | 1 | Sample-and-hold window active |
| convert_o | output | 1 | Conversion window active |
| eoc_o | output | 1 | End-of-conversion pulse |
| cfg_err_o | output | 1 | Illegal select code present |

## Verification
The vector table covers every stabilization tier, including the point where the table saturates. It measures the wait, sampling and conversion lengths in cycles. An off-by-one in any phase counter, or a wrong stabilization table, shows up as a count that misses by a cycle or more.

The directed tests each target one failure:
- An illegal code held with start high must never produce a window. A design that only checked bits [2:0] would start a div-1 conversion.
- An abort in mid-sampling followed by a new enable must show the full wait again. A design that forgot to re-arm would sample at once.
- A held start must reopen sampling on the cycle after the end-of-conversion pulse.
- A select change during sampling, and a stretch of idle ticks, must leave the measured windows at the lengths the latched code and the extra ticks imply.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STAB,
    ST_SAMP,
    ST_CONV
  } seq_state_e;

  // stabilization wait in base clocks, saturating above div 3
  function automatic int unsigned stab_base_clks(input int unsigned div);
    case (div)
      1:       return 16;
      2:       return 31;
      3:       return 47;
      default: return 50;
    endcase
  endfunction

endpackage

// File: rtl/adc_seq_decode.sv
module adc_seq_decode #(
  parameter int unsigned DIV_W     = 3,
  parameter int unsigned CNT_W     = 9,
  parameter int unsigned SAMP_HALF = 33,
  parameter int unsigned CONV_HALF = 62
) (
  input  logic [DIV_W-1:0] code_i,
  output logic [CNT_W-1:0] stab_last_o,
  output logic [CNT_W-1:0] samp_last_o,
  output logic [CNT_W-1:0] conv_last_o
);
  import adc_seq_pkg::*;

  int unsigned div_v;

  // all outputs are phase length in ticks minus one
  always_comb begin
    div_v       = 32'(code_i) + 32'd1;
    stab_last_o = CNT_W'(2 * stab_base_clks(div_v) - 1);
    samp_last_o = CNT_W'(SAMP_HALF * div_v - 1);
    conv_last_o = CNT_W'((CONV_HALF - SAMP_HALF) * div_v - 1);
  end

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (tick_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last_o = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_timing.sv
module adc_seq_timing #(
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned SAMP_HALF = 33,
  parameter int unsigned CONV_HALF = 62
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             enable_i,
  input  logic             start_i,
  input  logic [SEL_W-1:0] fsel_i,
  output logic             sample_o,
  output logic             convert_o,
  output logic             eoc_o,
  output logic             cfg_err_o
);
  import adc_seq_pkg::*;

  localparam int unsigned DIV_W   = SEL_W - 1;
  localparam int unsigned MAX_DIV = 1 << DIV_W;
  localparam int unsigned CNT_W   = $clog2(CONV_HALF * MAX_DIV + 1);

  seq_state_e       state_q, state_d;
  logic             armed_q, armed_d;
  logic [DIV_W-1:0] code_q, code_d;
  logic             err_q;

  logic [DIV_W-1:0] code_sel;
  logic [CNT_W-1:0] stab_last, samp_last, conv_last;
  logic             load, last;
  logic [CNT_W-1:0] load_val;
  logic             go;

  assign go = start_i && !fsel_i[SEL_W-1];

  // idle and restart decisions use the live code, running phases the captured one
  assign code_sel = (state_q == ST_IDLE || state_q == ST_CONV) ? fsel_i[DIV_W-1:0] : code_q;

  adc_seq_decode #(
    .DIV_W    (DIV_W),
    .CNT_W    (CNT_W),
    .SAMP_HALF(SAMP_HALF),
    .CONV_HALF(CONV_HALF)
  ) u_decode (
    .code_i     (code_sel),
    .stab_last_o(stab_last),
    .samp_last_o(samp_last),
    .conv_last_o(conv_last)
  );

  adc_seq_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .load_i    (load),
    .load_val_i(load_val),
    .last_o    (last)
  );

  always_comb begin
    state_d  = state_q;
    armed_d  = armed_q;
    code_d   = code_q;
    load     = 1'b0;
    load_val = samp_last;
    if (!enable_i) begin
      state_d = ST_IDLE;
      armed_d = 1'b1;
    end else if (tick_i) begin
      unique case (state_q)
        ST_IDLE: begin
          if (go) begin
            code_d = fsel_i[DIV_W-1:0];
            load   = 1'b1;
            if (armed_q) begin
              state_d  = ST_STAB;
              load_val = stab_last;
            end else begin
              state_d  = ST_SAMP;
              load_val = samp_last;
            end
          end
        end
        ST_STAB: begin
          if (last) begin
            state_d  = ST_SAMP;
            armed_d  = 1'b0;
            load     = 1'b1;
            load_val = samp_last;
          end
        end
        ST_SAMP: begin
          if (last) begin
            state_d  = ST_CONV;
            load     = 1'b1;
            load_val = conv_last;
          end
        end
        ST_CONV: begin
          if (last) begin
            if (go) begin
              state_d  = ST_SAMP;
              code_d   = fsel_i[DIV_W-1:0];
              load     = 1'b1;
              load_val = samp_last;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      armed_q <= 1'b1;
      code_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
      code_q  <= code_d;
      err_q   <= fsel_i[SEL_W-1];
    end
  end

  assign sample_o  = (state_q == ST_SAMP);
  assign convert_o = (state_q == ST_CONV);
  assign eoc_o     = enable_i && tick_i && (state_q == ST_CONV) && last;
  assign cfg_err_o = err_q;

endmodule

// File: rtl/adc_seq_timing_chk.sv
module adc_seq_timing_chk #(
  parameter int unsigned SEL_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             enable_i,
  input logic [SEL_W-1:0] fsel_i,
  input logic             sample_o,
  input logic             convert_o,
  input logic             eoc_o,
  input logic             cfg_err_o,
  input logic             idle_i
);

  a_r11_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_o && convert_o));

  a_r6_eoc_in_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |-> convert_o);

  a_r6_eoc_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |=> !eoc_o);

  a_r8_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!sample_o && !convert_o));

  a_r7_err_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsel_i[SEL_W-1] |=> cfg_err_o);

  a_r7_err_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fsel_i[SEL_W-1] |=> !cfg_err_o);

  a_r7_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && fsel_i[SEL_W-1]) |=> idle_i);

  a_r10_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !tick_i) |=> ($stable(sample_o) && $stable(convert_o)));

endmodule

bind adc_seq_timing adc_seq_timing_chk #(.SEL_W(SEL_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .enable_i (enable_i),
  .fsel_i   (fsel_i),
  .sample_o (sample_o),
  .convert_o(convert_o),
  .eoc_o    (eoc_o),
  .cfg_err_o(cfg_err_o),
  .idle_i   (state_q == adc_seq_pkg::ST_IDLE)
);

// File: tb/adc_seq_timing_tb_top.sv
`timescale 1ns/1ps
module adc_seq_timing_tb_top;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       enable_i = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] fsel_i = 4'd0;
  logic       sample_o, convert_o, eoc_o, cfg_err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  adc_seq_timing dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .enable_i (enable_i),
    .start_i  (start_i),
    .fsel_i   (fsel_i),
    .sample_o (sample_o),
    .convert_o(convert_o),
    .eoc_o    (eoc_o),
    .cfg_err_o(cfg_err_o)
  );

  typedef struct packed {
    logic [3:0] sel;
    logic       arm;
    logic [9:0] gap;
    logic [9:0] samp;
    logic [9:0] conv;
    logic [3:0] mid;
  } vec_t;

  // gap = 2 x stabilization base clocks when armed, samp = 33*div, conv = 29*div
  localparam vec_t VECS [8] = '{
    '{4'd0, 1'b1, 10'd32,  10'd33,  10'd29,  4'd0},
    '{4'd1, 1'b1, 10'd62,  10'd66,  10'd58,  4'd1},
    '{4'd2, 1'b1, 10'd94,  10'd99,  10'd87,  4'd2},
    '{4'd3, 1'b1, 10'd100, 10'd132, 10'd116, 4'd3},
    '{4'd7, 1'b1, 10'd100, 10'd264, 10'd232, 4'd7},
    '{4'd4, 1'b0, 10'd0,   10'd165, 10'd145, 4'd4},
    '{4'd5, 1'b0, 10'd0,   10'd198, 10'd174, 4'd0},
    '{4'd6, 1'b1, 10'd100, 10'd231, 10'd203, 4'd6}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rearm();
    enable_i = 1'b0;
    repeat (2) @(negedge clk_i);
    enable_i = 1'b1;
  endtask

  // called at a negedge; drives start and measures every phase in cycles
  task automatic measure(input logic [3:0] sel, input int gap, input int samp,
                         input int conv, input logic [3:0] mid, input int frz,
                         input string stag);
    int gap_n = 0;
    int s_n = 0;
    int c_n = 0;
    int e_n = 0;
    int e_at = -1;
    int frz_left = 0;
    bit done_l = 1'b0;
    fsel_i  = sel;
    start_i = 1'b1;
    for (int k = 0; k < 2000 && !done_l; k++) begin
      @(negedge clk_i);
      if (frz_left > 0) begin
        frz_left--;
        if (frz_left == 0) tick_i = 1'b1;
      end
      if (sample_o) begin
        s_n++;
        if (s_n == 1) begin
          start_i = 1'b0;
          fsel_i  = mid;
          if (frz > 0) begin
            tick_i   = 1'b0;
            frz_left = frz;
          end
        end
      end else if (convert_o) begin
        c_n++;
        if (eoc_o) begin
          e_n++;
          e_at = c_n;
        end
      end else if (s_n == 0) begin
        gap_n++;
      end else begin
        done_l = 1'b1;
      end
    end
    chk(gap_n == gap, (gap == 0) ? "R5 no stabilization" : "R4 stabilization", gap_n, gap);
    chk(s_n == samp, stag, s_n, samp);
    chk(c_n == conv, "R3 conversion window", c_n, conv);
    chk(e_n == 1 && e_at == conv, "R6 eoc position", e_at, conv);
  endtask

  initial begin
    repeat (5000 * 30) @(posedge clk_i);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!sample_o && !convert_o && !eoc_o && !cfg_err_o, "R1 in reset", 1, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b1;
    @(negedge clk_i);
    chk(sample_o == 1'b0,  "R1 sample after reset",  int'(sample_o), 0);
    chk(convert_o == 1'b0, "R1 convert after reset", int'(convert_o), 0);
    chk(eoc_o == 1'b0,     "R1 eoc after reset",     int'(eoc_o), 0);
    chk(cfg_err_o == 1'b0, "R1 error after reset",   int'(cfg_err_o), 0);

    // vector walk: R2 R3 R4 R5 R6, row 6 exercises R9
    enable_i = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (VECS[i].arm) rearm();
      measure(VECS[i].sel, int'(VECS[i].gap), int'(VECS[i].samp), int'(VECS[i].conv),
              VECS[i].mid, 0, (VECS[i].mid != VECS[i].sel) ? "R9 latched select" : "R2 sampling window");
    end

    // R7 illegal code blocks start
    begin
      int hits = 0;
      fsel_i  = 4'd8;
      start_i = 1'b1;
      @(negedge clk_i);
      chk(cfg_err_o == 1'b1, "R7 error raised", int'(cfg_err_o), 1);
      for (int k = 0; k < 120; k++) begin
        @(negedge clk_i);
        if (sample_o || convert_o) hits++;
      end
      chk(hits == 0, "R7 start blocked", hits, 0);
      fsel_i  = 4'd2;
      start_i = 1'b0;
      @(negedge clk_i);
      chk(cfg_err_o == 1'b0, "R7 error cleared", int'(cfg_err_o), 0);
    end

    // R8 abort during sampling, then re-armed stabilization
    begin
      int waited = 0;
      fsel_i  = 4'd0;
      start_i = 1'b1;
      while (!sample_o && waited < 300) begin
        @(negedge clk_i);
        waited++;
      end
      start_i = 1'b0;
      repeat (3) @(negedge clk_i);
      enable_i = 1'b0;
      @(negedge clk_i);
      chk(!sample_o && !convert_o, "R8 abort", int'(sample_o) + int'(convert_o), 0);
      enable_i = 1'b1;
      measure(4'd0, 32, 33, 29, 4'd0, 0, "R8 re-armed run sampling");
    end

    // R5 back-to-back with start held
    begin
      int waited = 0;
      fsel_i  = 4'd0;
      start_i = 1'b1;
      while (!eoc_o && waited < 300) begin
        @(negedge clk_i);
        waited++;
      end
      @(negedge clk_i);
      chk(sample_o && !convert_o, "R5 immediate resample", int'(sample_o), 1);
      start_i = 1'b0;
      waited = 0;
      while ((sample_o || convert_o) && waited < 300) begin
        @(negedge clk_i);
        waited++;
      end
    end

    // R10 ten idle ticks stretch sampling by ten cycles
    measure(4'd0, 0, 43, 29, 4'd0, 10, "R10 tick freeze");

    // R11 no overlap seen during a run is covered by assertion; check idle here
    chk(!sample_o && !convert_o, "R11 idle at end", int'(sample_o) + int'(convert_o), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule